// File: doc/BRIEF.md
# Hierarchical Address Predecoder with Byte Strobes

This block turns a word address into a one-hot set of word-select lines for a single-port memory, and forms a write strobe for every word and byte lane of that memory. The decode is built in three explicit stages of two-input gates with alternating polarity. Address bit pairs first produce active-low quarter selects through NAND gates. NOR gates then join pairs of those into active-high nibble selects. A final NAND stage joins one low-nibble select with one high-nibble select to give an active-low select for each word.

Each write strobe is a three-input NOR of active-low terms: the word's select, the inverted chip enable and the inverted lane enable. The memory's per-bit input multiplexers load new data while their strobe is high and recirculate the stored bit otherwise. The block also registers the decoded one-hot on every rising edge, for use as the read select. It also keeps a registered read address, which loads only while chip enable is high. The storage array and the read multiplexer sit outside this block.

Top module: `addr_predecode`

## Requirements
- R1: For every address value, `word_sel` has exactly one bit set, and that bit's index equals `addr` read as an unsigned number.
- R2: Strobe bit `w*LANES + b` of `wr_strobe` is high exactly when `ce` is 1, `lane_we[b]` is 1 and `addr` equals `w`, where lane b covers data bits 8b+7..8b.
- R3: While `ce` is 0, every bit of `wr_strobe` is 0, whatever `addr` and `lane_we` hold.
- R4: On each rising edge with `rst_n` high, `rd_sel` takes the value `word_sel` had before that edge, regardless of `ce`.
- R5: On a rising edge with `rst_n` high and `ce` high, `rd_addr` takes the value of `addr`.
- R6: On a rising edge with `rst_n` high and `ce` low, `rd_addr` keeps its previous value.
- R7: On a rising edge with `rst_n` low, `rd_sel` and `rd_addr` both become all zeros.
- R8: With `ce` high and `lane_we` all zeros, no bit of `wr_strobe` is set.
- R9: `word_sel` follows `addr` combinationally whatever the level of `ce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Chip enable, active high |
| lane_we | input | LANES (4) | Byte-lane write enables, active high |
| addr | input | ADDR_W (8) | Word address |
| word_sel | output | 2**ADDR_W (256) | Combinational one-hot word select |
| wr_strobe | output | 2**ADDR_W*LANES (1024) | Per-word, per-lane write strobes, word-major order |
| rd_sel | output | 2**ADDR_W (256) | Registered one-hot read select |
| rd_addr | output | ADDR_W (8) | Registered read address, loaded while `ce` is high |

## Verification
The assertions assume that `addr`, `lane_we` and `ce` hold known 0/1 values at every clock edge after reset, because one-hot validity and strobe absence mean nothing for unknown inputs. The stimulus changes all inputs only on falling edges. It starts from a known state at time zero and never leaves an input undriven, so each rising edge sees settled values. After reset, each walk over the address space gives the registered outputs a full cycle in which the one-cycle-delay relations can be observed.

// File: rtl/pdec_pkg.sv
// Package: shared constants and a literal-select helper for the predecoder.
// Assumes the address splits into bit pairs grouped two per nibble field.
package pdec_pkg;

    // Lines produced by one 2-bit pair and by one 4-bit field.
    localparam int PAIR_LINES  = 4;
    localparam int FIELD_LINES = 16;

    // Return the true or inverted address literal that a decode value needs.
    function automatic logic addr_lit(input logic bit_in, input int want_one);
        return (want_one != 0) ? bit_in : ~bit_in;
    endfunction

endpackage

// File: rtl/pdec_pair_stage.sv
// Module: first decode level. Each 2-bit address pair yields four
// active-low lines through two-input NAND gates of true or inverted bits.
// Assumes ADDR_W is even.
module pdec_pair_stage
    import pdec_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]                  addr,
    output logic [(ADDR_W/2)*PAIR_LINES-1:0]   pair_n
);
    localparam int NPAIR = ADDR_W / 2;

    // One NAND per pair and per 2-bit value.
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        for (genvar v = 0; v < PAIR_LINES; v++) begin : g_val
            assign pair_n[p*PAIR_LINES + v] =
                ~(addr_lit(addr[2*p],     v & 1) &
                  addr_lit(addr[2*p + 1], (v >> 1) & 1));
        end
    end
endmodule

// File: rtl/pdec_field_stage.sv
// Module: second decode level. Two adjacent pair groups are combined by
// two-input NOR gates into sixteen active-high lines per 4-bit field.
// Assumes ADDR_W is a multiple of four.
module pdec_field_stage
    import pdec_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [(ADDR_W/2)*PAIR_LINES-1:0]   pair_n,
    output logic [(ADDR_W/4)*FIELD_LINES-1:0]  field_sel
);
    localparam int NFIELD = ADDR_W / 4;

    // One NOR per field and per 4-bit value: low pair and high pair terms.
    for (genvar f = 0; f < NFIELD; f++) begin : g_field
        for (genvar u = 0; u < FIELD_LINES; u++) begin : g_val
            localparam int LO = u % PAIR_LINES;
            localparam int HI = u / PAIR_LINES;
            assign field_sel[f*FIELD_LINES + u] =
                ~(pair_n[(2*f)*PAIR_LINES + LO] |
                  pair_n[(2*f + 1)*PAIR_LINES + HI]);
        end
    end
endmodule

// File: rtl/pdec_word_stage.sv
// Module: third decode level and write strobes. A NAND of one low-field
// and one high-field line gives each active-low word select; a NOR3 of
// active-low terms gives each word/lane strobe. Assumes exactly two fields.
module pdec_word_stage
    import pdec_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic [(ADDR_W/4)*FIELD_LINES-1:0]  field_sel,
    input  logic                               ce_n,
    input  logic [LANES-1:0]                   lane_we_n,
    output logic [(1<<ADDR_W)-1:0]             word_n,
    output logic [(1<<ADDR_W)*LANES-1:0]       strobe
);
    localparam int WORDS = 1 << ADDR_W;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam int LO = w % FIELD_LINES;
        localparam int HI = w / FIELD_LINES;
        // Word decode: NAND of the two nibble selects.
        assign word_n[w] = ~(field_sel[LO] & field_sel[FIELD_LINES + HI]);
        // Lane strobes: NOR of word select, chip enable and lane enable.
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            assign strobe[w*LANES + b] = ~(word_n[w] | ce_n | lane_we_n[b]);
        end
    end
endmodule

// File: rtl/pdec_read_regs.sv
// Module: read-side registers. Captures the active-high one-hot every
// edge and keeps a read address that loads only while chip enable is high.
// Assumes a synchronous active-low reset.
module pdec_read_regs #(
    parameter int ADDR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ce,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [(1<<ADDR_W)-1:0]     onehot,
    output logic [(1<<ADDR_W)-1:0]     rd_sel,
    output logic [ADDR_W-1:0]          rd_addr
);
    logic [ADDR_W-1:0] addr_nxt;

    // Recirculating 2:1 mux in front of the address register.
    always_comb addr_nxt = ce ? addr : rd_addr;

    // Register the one-hot read select and the read address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_sel  <= '0;
            rd_addr <= '0;
        end else begin
            rd_sel  <= onehot;
            rd_addr <= addr_nxt;
        end
    end

    p_sel_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> rd_sel == $past(onehot));
    p_addr_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ce |=> rd_addr == $past(addr));
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(rd_addr));
    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> (rd_sel == '0 && rd_addr == '0));
endmodule

// File: rtl/addr_predecode.sv
// Module: top of the hierarchical predecoder. Chains the pair, field and
// word stages, exposes the active-high one-hot and strobes, and holds the
// read-side registers. Assumes ADDR_W = 8 (two nibble fields).
module addr_predecode
    import pdec_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ce,
    input  logic [LANES-1:0]              lane_we,
    input  logic [ADDR_W-1:0]             addr,
    output logic [(1<<ADDR_W)-1:0]        word_sel,
    output logic [(1<<ADDR_W)*LANES-1:0]  wr_strobe,
    output logic [(1<<ADDR_W)-1:0]        rd_sel,
    output logic [ADDR_W-1:0]             rd_addr
);
    localparam int WORDS = 1 << ADDR_W;

    logic [(ADDR_W/2)*PAIR_LINES-1:0]  pair_n;
    logic [(ADDR_W/4)*FIELD_LINES-1:0] field_sel;
    logic [WORDS-1:0]                  word_n;
    logic                              ce_n;
    logic [LANES-1:0]                  lane_we_n;

    // Active-low copies of the enables for the strobe NOR gates.
    always_comb begin
        ce_n      = ~ce;
        lane_we_n = ~lane_we;
    end

    pdec_pair_stage  #(.ADDR_W(ADDR_W)) u_pair  (.addr(addr), .pair_n(pair_n));
    pdec_field_stage #(.ADDR_W(ADDR_W)) u_field (.pair_n(pair_n), .field_sel(field_sel));
    pdec_word_stage  #(.ADDR_W(ADDR_W), .LANES(LANES)) u_word (
        .field_sel (field_sel),
        .ce_n      (ce_n),
        .lane_we_n (lane_we_n),
        .word_n    (word_n),
        .strobe    (wr_strobe)
    );

    // Invert the active-low word decode to the active-high one-hot.
    always_comb word_sel = ~word_n;

    pdec_read_regs #(.ADDR_W(ADDR_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce      (ce),
        .addr    (addr),
        .onehot  (word_sel),
        .rd_sel  (rd_sel),
        .rd_addr (rd_addr)
    );

    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(word_sel) == 1);
    p_sel_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
        word_sel[addr] == 1'b1);
    p_no_strobe_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |-> wr_strobe == '0);
    p_no_strobe_lanes_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we == '0) |-> wr_strobe == '0);
    p_strobe_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ce |-> $countones(wr_strobe) == $countones(lane_we));
endmodule

// File: tb/addr_predecode_test.sv
module addr_predecode_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int LANES  = 4;
    localparam int WORDS  = 1 << ADDR_W;

    // Vector: {ce, lane_we, addr, expected strobe nibble at that word}
    localparam logic [16:0] VEC [12] = '{
        {1'b1, 4'hF, 8'h00, 4'hF},
        {1'b1, 4'h1, 8'hFF, 4'h1},
        {1'b1, 4'hA, 8'h55, 4'hA},
        {1'b0, 4'hF, 8'hAA, 4'h0},
        {1'b1, 4'h0, 8'h3C, 4'h0},
        {1'b1, 4'h8, 8'h80, 4'h8},
        {1'b0, 4'h5, 8'h01, 4'h0},
        {1'b1, 4'h2, 8'h7F, 4'h2},
        {1'b1, 4'h4, 8'hC3, 4'h4},
        {1'b0, 4'h0, 8'h10, 4'h0},
        {1'b1, 4'h6, 8'hFE, 4'h6},
        {1'b1, 4'h9, 8'h01, 4'h9}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce = 1'b0;
    logic [LANES-1:0] lane_we = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic [WORDS-1:0] word_sel;
    logic [WORDS*LANES-1:0] wr_strobe;
    logic [WORDS-1:0] rd_sel;
    logic [ADDR_W-1:0] rd_addr;

    int n_checks = 0;
    int n_fail = 0;
    logic [ADDR_W-1:0] exp_rd_addr = '0;

    addr_predecode #(.ADDR_W(ADDR_W), .LANES(LANES)) uut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .lane_we(lane_we), .addr(addr),
        .word_sel(word_sel), .wr_strobe(wr_strobe), .rd_sel(rd_sel), .rd_addr(rd_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string act, input string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    function automatic logic [WORDS*LANES-1:0] ref_strobe(
        input logic c, input logic [LANES-1:0] we, input logic [ADDR_W-1:0] a);
        logic [WORDS*LANES-1:0] r = '0;
        for (int w = 0; w < WORDS; w++)
            for (int b = 0; b < LANES; b++)
                r[w*LANES + b] = c && we[b] && (a == w[ADDR_W-1:0]);
        return r;
    endfunction

    function automatic logic [WORDS-1:0] ref_onehot(input logic [ADDR_W-1:0] a);
        logic [WORDS-1:0] r = '0;
        r[a] = 1'b1;
        return r;
    endfunction

    // Drive at falling edge, check combinational outputs, then registers.
    task automatic apply(input logic c, input logic [LANES-1:0] we,
                         input logic [ADDR_W-1:0] a, input bit check_regs);
        @(negedge clk);
        ce = c; lane_we = we; addr = a;
        #1;
        check(word_sel == ref_onehot(a), "R1/R9 word_sel",
              $sformatf("%h", word_sel), $sformatf("%h", ref_onehot(a)));
        check(wr_strobe == ref_strobe(c, we, a), c ? "R2 wr_strobe" : "R3 wr_strobe",
              $sformatf("%h", wr_strobe), $sformatf("%h", ref_strobe(c, we, a)));
        if (check_regs) begin
            if (c) exp_rd_addr = a;
            @(posedge clk);
            #1;
            check(rd_sel == ref_onehot(a), "R4 rd_sel",
                  $sformatf("%h", rd_sel), $sformatf("%h", ref_onehot(a)));
            check(rd_addr == exp_rd_addr, c ? "R5 rd_addr" : "R6 rd_addr",
                  $sformatf("%h", rd_addr), $sformatf("%h", exp_rd_addr));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R7: reset state
        addr = 8'h5A; ce = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check(rd_sel == '0, "R7 rd_sel reset", $sformatf("%h", rd_sel), "0");
        check(rd_addr == '0, "R7 rd_addr reset", $sformatf("%h", rd_addr), "0");
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < 12; i++) begin
            apply(VEC[i][16], VEC[i][15:12], VEC[i][11:4], 1'b1);
            check(wr_strobe[VEC[i][11:4]*LANES +: LANES] == VEC[i][3:0], "R2/R8 table nibble",
                  $sformatf("%h", wr_strobe[VEC[i][11:4]*LANES +: LANES]),
                  $sformatf("%h", VEC[i][3:0]));
        end

        // Exhaustive sweeps: all lanes enabled, then chip disabled (R3, R9)
        for (int a = 0; a < WORDS; a++) apply(1'b1, 4'hF, a[ADDR_W-1:0], 1'b0);
        for (int a = 0; a < WORDS; a++) apply(1'b0, 4'hF, a[ADDR_W-1:0], 1'b0);
        // R8: all lanes off with chip enabled
        for (int a = 0; a < WORDS; a += 17) apply(1'b1, 4'h0, a[ADDR_W-1:0], 1'b1);

        // Random stimulus with register checks
        for (int i = 0; i < 300; i++)
            apply(1'($urandom), 4'($urandom), 8'($urandom), 1'b1);

        // R6: hold across several disabled cycles
        apply(1'b1, 4'h3, 8'hA7, 1'b1);
        for (int i = 0; i < 4; i++) apply(1'b0, 4'hF, 8'(8'h10 + i), 1'b1);

        // R7: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0; ce = 1'b1; addr = 8'hC4;
        @(posedge clk);
        #1;
        check(rd_sel == '0, "R7 rd_sel mid reset", $sformatf("%h", rd_sel), "0");
        check(rd_addr == '0, "R7 rd_addr mid reset", $sformatf("%h", rd_addr), "0");
        @(negedge clk);
        rst_n = 1'b1;
        exp_rd_addr = '0;
        apply(1'b1, 4'hF, 8'h3E, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule